// File: doc/BRIEF.md
# Auxiliary RAM Access Router

This block sits between the external-data move path of an 8-bit microcontroller core and two destinations: a 256-byte on-chip auxiliary RAM and the off-chip memory bus interface. Each request carries a read/write flag, a source selector that says whether the address comes from the 8-bit indirect register of the active bank or from the 16-bit data pointer, both address values and the write data. The router forms a 16-bit address and decides where the access goes.

A chip control register holds the enable bit at position 4. The bit is clear after reset, so every access leaves the chip until software sets it. With the bit set, addresses 0 to 255 go to the on-chip RAM. Anything above 255 always goes off-chip. An 8-bit indirect pointer is zero-extended, so with the RAM enabled it can only reach on-chip storage.

On-chip accesses complete one cycle after they are accepted. Off-chip accesses are held on the bus request port until it acknowledges, and the router takes no new request while one is outstanding. The bus timing itself belongs to the bus controller.

Top module: `xram_router`

## Requirements
- R1: After reset the enable bit is clear, so a request to any address 0..255 raises `ext_req` and never `ram_en`.
- R2: A write on the control port (`ctl_we`=1) loads the enable from `ctl_wdata` bit 4 (1 = on-chip RAM enabled, 0 = disabled). The other seven bits have no effect on routing. The new value applies to requests accepted after the write's clock edge.
- R3: With the RAM enabled, a data-pointer request (`req_src`=1) whose address is 0..255 asserts `ram_en` combinationally in its request cycle, with `ram_addr` equal to the low address byte. No external request is raised.
- R4: A data-pointer request whose address is above 255 goes to the external port whatever the enable bit is, with `ext_addr` equal to the full 16-bit pointer.
- R5: An indirect request (`req_src`=0) uses address {8'h00, `req_ptr`}. With the RAM enabled it always goes on-chip. With the RAM disabled it goes off-chip with that zero-extended `ext_addr`.
- R6: An on-chip access gives `rsp_valid`=1 in the cycle after acceptance. For a read, `rsp_rdata` then equals the RAM's read data.
- R7: An off-chip request holds `ext_req`, `ext_addr`, `ext_we` and `ext_wdata` stable until the cycle `ext_ack`=1. `ext_req` drops in the next cycle, and `rsp_valid`=1 there with `rsp_rdata` equal to the `ext_rdata` value sampled with the acknowledge.
- R8: While an off-chip access is outstanding, `req_ready`=0. A request presented then is ignored: no `ram_en`, and no second external access.
- R9: A write passes `req_wdata` unchanged to `ram_wdata` with `ram_we`=1 for on-chip targets, or to `ext_wdata` with `ext_we`=1 for off-chip targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Chip control register write strobe |
| ctl_wdata | input | 8 | Control register write value, bit 4 = RAM enable |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Router can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | 1 | 0 = 8-bit indirect pointer, 1 = 16-bit data pointer |
| req_ptr | input | 8 | Indirect pointer value |
| req_dptr | input | 16 | Data pointer value |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Access complete |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid |
| ram_en | output | 1 | On-chip RAM access strobe |
| ram_we | output | 1 | On-chip RAM write |
| ram_addr | output | 8 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data, one cycle after ram_en |
| ext_req | output | 1 | External bus request, held until acknowledged |
| ext_we | output | 1 | External write |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_ack | input | 1 | External bus acknowledge |
| ext_rdata | input | 8 | External read data, sampled with ext_ack |

## Verification
The bench goes after the 255/256 boundary on the data pointer. A wrong range compare would either send address 256 to on-chip RAM, where it aliases onto byte 0, or push address 255 off-chip. It drives pointer 0xFF through the indirect path in both enable states. A design that sign-extended or dropped the zero extension would show the wrong external address or leave the on-chip window. It also writes control values whose bit 4 is clear but whose other bits are set, which catches a decode of the wrong bit. Finally it presents requests while an off-chip access is pending and acknowledges after varying delays. A router that accepted such a request would pulse `ram_en` or corrupt the held bus address.

// File: rtl/xram_pkg.sv
package xram_pkg;
   typedef enum logic [0:0] {
      SRC_INDIRECT = 1'b0,
      SRC_DPTR     = 1'b1
   } ptr_src_e;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_WAIT = 1'b1
   } ext_state_e;
endpackage

// File: rtl/xram_ctl_reg.sv
module xram_ctl_reg #(
   parameter int CTL_W  = 8,
   parameter int EN_BIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output logic             aux_en
);
   if (EN_BIT >= CTL_W) begin : g_bad_bit
      $error("xram_ctl_reg: EN_BIT outside control word");
   end

   wire ctl_unused_bits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  aux_en <= 1'b0;
      else if (we) aux_en <= wdata[EN_BIT];
   end
endmodule

// File: rtl/xram_addr_dec.sv
module xram_addr_dec
   import xram_pkg::*;
#(
   parameter int PTR_W  = 8,
   parameter int ADDR_W = 16,
   parameter int AUX_AW = 8
) (
   input  ptr_src_e          src,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [ADDR_W-1:0] dptr,
   input  logic              aux_en,
   output logic [ADDR_W-1:0] addr,
   output logic              hit
);
   if (PTR_W > ADDR_W) begin : g_bad_ptr
      $error("xram_addr_dec: PTR_W wider than ADDR_W");
   end
   if (AUX_AW >= ADDR_W) begin : g_bad_aux
      $error("xram_addr_dec: AUX_AW must be below ADDR_W");
   end

   logic [ADDR_W-1:0] ptr_ext;

   if (PTR_W < ADDR_W) begin : g_zext
      assign ptr_ext = {{(ADDR_W-PTR_W){1'b0}}, ptr};
   end else begin : g_full
      assign ptr_ext = ptr;
   end

   always_comb begin
      addr = (src == SRC_DPTR) ? dptr : ptr_ext;
      hit  = aux_en && (addr[ADDR_W-1:AUX_AW] == '0);
   end
endmodule

// File: rtl/xram_ext_seq.sv
module xram_ext_seq
   import xram_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              we_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   output logic              busy,
   output logic              ext_req,
   output logic              ext_we,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_wdata,
   input  logic              ext_ack,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata_q
);
   ext_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         ext_we    <= 1'b0;
         ext_addr  <= '0;
         ext_wdata <= '0;
         done      <= 1'b0;
         rdata_q   <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            SEQ_IDLE: if (start) begin
               state     <= SEQ_WAIT;
               ext_we    <= we_in;
               ext_addr  <= addr_in;
               ext_wdata <= wdata_in;
            end
            SEQ_WAIT: if (ext_ack) begin
               state   <= SEQ_IDLE;
               done    <= 1'b1;
               rdata_q <= ext_rdata;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign ext_req = (state == SEQ_WAIT);
   assign busy    = ext_req;
endmodule

// File: rtl/xram_router.sv
module xram_router
   import xram_pkg::*;
#(
   parameter int CTL_W  = 8,
   parameter int EN_BIT = 4,
   parameter int PTR_W  = 8,
   parameter int ADDR_W = 16,
   parameter int AUX_AW = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_src,
   input  logic [PTR_W-1:0]  req_ptr,
   input  logic [ADDR_W-1:0] req_dptr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              ram_en,
   output logic              ram_we,
   output logic [AUX_AW-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              ext_req,
   output logic              ext_we,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_wdata,
   input  logic              ext_ack,
   input  logic [DATA_W-1:0] ext_rdata
);
   logic              aux_en;
   logic [ADDR_W-1:0] acc_addr;
   logic              acc_hit;
   logic              accept;
   logic              ext_busy;
   logic              ext_done;
   logic [DATA_W-1:0] ext_rdata_q;
   logic              ram_rsp_q;

   xram_ctl_reg #(.CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ctl_we),
      .wdata  (ctl_wdata),
      .aux_en (aux_en)
   );

   xram_addr_dec #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .AUX_AW(AUX_AW)) u_dec (
      .src    (ptr_src_e'(req_src)),
      .ptr    (req_ptr),
      .dptr   (req_dptr),
      .aux_en (aux_en),
      .addr   (acc_addr),
      .hit    (acc_hit)
   );

   assign req_ready = !ext_busy;
   assign accept    = req_valid && req_ready;

   assign ram_en    = accept && acc_hit;
   assign ram_we    = req_write;
   assign ram_addr  = acc_addr[AUX_AW-1:0];
   assign ram_wdata = req_wdata;

   xram_ext_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept && !acc_hit),
      .we_in     (req_write),
      .addr_in   (acc_addr),
      .wdata_in  (req_wdata),
      .busy      (ext_busy),
      .ext_req   (ext_req),
      .ext_we    (ext_we),
      .ext_addr  (ext_addr),
      .ext_wdata (ext_wdata),
      .ext_ack   (ext_ack),
      .ext_rdata (ext_rdata),
      .done      (ext_done),
      .rdata_q   (ext_rdata_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ram_rsp_q <= 1'b0;
      else        ram_rsp_q <= ram_en;
   end

   assign rsp_valid = ram_rsp_q || ext_done;
   assign rsp_rdata = ext_done ? ext_rdata_q : ram_rdata;
endmodule

// File: rtl/xram_router_chk.sv
module xram_router_chk #(
   parameter int ADDR_W = 16,
   parameter int AUX_AW = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              req_src,
   input logic [ADDR_W-1:0] req_dptr,
   input logic              rsp_valid,
   input logic              ram_en,
   input logic              ram_we,
   input logic              ext_req,
   input logic              ext_we,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [DATA_W-1:0] ext_wdata,
   input logic              ext_ack
);
   AST_RAM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en |-> !ext_req); // R3

   AST_HIGH_OFFCHIP: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && req_src) |-> ((req_dptr >> AUX_AW) == '0)); // R4

   AST_RAM_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && !ram_we) |=> rsp_valid); // R6

   AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)
                                 && $stable(ext_we) && $stable(ext_wdata))); // R7

   AST_EXT_ACK_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && ext_ack) |=> (rsp_valid && !ext_req)); // R7

   AST_BUSY_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> !ram_en); // R8
endmodule

bind xram_router xram_router_chk #(
   .ADDR_W(ADDR_W), .AUX_AW(AUX_AW), .DATA_W(DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .req_src   (req_src),
   .req_dptr  (req_dptr),
   .rsp_valid (rsp_valid),
   .ram_en    (ram_en),
   .ram_we    (ram_we),
   .ext_req   (ext_req),
   .ext_we    (ext_we),
   .ext_addr  (ext_addr),
   .ext_wdata (ext_wdata),
   .ext_ack   (ext_ack)
);

// File: tb/xram_router_tb_top.sv
`timescale 1ns/1ps
module xram_router_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_src = 1'b0;
   logic [7:0]  req_ptr = '0;
   logic [15:0] req_dptr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic        ram_en, ram_we;
   logic [7:0]  ram_addr, ram_wdata;
   logic [7:0]  ram_rdata = '0;
   logic        ext_req, ext_we;
   logic [15:0] ext_addr;
   logic [7:0]  ext_wdata;
   logic        ext_ack = 1'b0;
   logic [7:0]  ext_rdata = '0;

   int total = 0;
   int bad   = 0;
   logic       en_model = 1'b0;
   logic [7:0] ram_mem [256];
   logic [7:0] shadow  [256];

   always #10 clk = ~clk;

   xram_router dut_i (.*);

   // on-chip RAM model: synchronous read, one cycle latency
   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) ram_mem[ram_addr] <= ram_wdata;
         ram_rdata <= ram_mem[ram_addr];
      end
   end

   function automatic logic [7:0] ext_val(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [15:0] exp_addr(input logic src, input logic [7:0] p,
                                            input logic [15:0] d);
      return src ? d : {8'h00, p};
   endfunction

   function automatic logic exp_onchip(input logic en, input logic [15:0] a);
      return en && (a < 16'd256);
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [7:0] v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
      en_model = v[4];
   endtask

   task automatic access(input logic wr, input logic src, input logic [7:0] p,
                         input logic [15:0] d, input logic [7:0] wd, input int dly);
      logic [15:0] a;
      logic        onc;
      logic [7:0]  exp_rd;
      a   = exp_addr(src, p, d);
      onc = exp_onchip(en_model, a);
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
      req_valid = 1'b1; req_write = wr; req_src = src;
      req_ptr = p; req_dptr = d; req_wdata = wd;
      #1;
      if (src) chk(ram_en == onc, onc ? "R3 on-chip route" : "R4/R1 off-chip route", ram_en, onc);
      else     chk(ram_en == onc, "R5 indirect route", ram_en, onc);
      if (onc) begin
         chk(ram_addr == a[7:0], "R3 ram_addr", ram_addr, a[7:0]);
         chk(ram_we == wr, "R9 ram_we", ram_we, wr);
         if (wr) chk(ram_wdata == wd, "R9 ram_wdata", ram_wdata, wd);
         exp_rd = shadow[a[7:0]];
         if (wr) shadow[a[7:0]] = wd;
         @(negedge clk);
         req_valid = 1'b0;
         chk(rsp_valid == 1'b1, "R6 rsp_valid next cycle", rsp_valid, 1);
         chk(ext_req == 1'b0, "R3 no ext_req", ext_req, 0);
         if (!wr) chk(rsp_rdata == exp_rd, "R6 on-chip read data", rsp_rdata, exp_rd);
      end else begin
         @(negedge clk);
         req_valid = 1'b0;
         chk(ext_req == 1'b1, "R7 ext_req raised", ext_req, 1);
         chk(ext_addr == a, src ? "R4 ext_addr" : "R5 zero-extended ext_addr", ext_addr, a);
         chk(ext_we == wr, "R9 ext_we", ext_we, wr);
         if (wr) chk(ext_wdata == wd, "R9 ext_wdata", ext_wdata, wd);
         for (int k = 0; k < dly; k++) begin
            if (k == 0) begin
               // spurious request while busy: must be ignored
               req_valid = 1'b1; req_src = 1'b1; req_dptr = 16'h0003; req_write = 1'b1;
               #1;
               chk(req_ready == 1'b0, "R8 not ready while busy", req_ready, 0);
               chk(ram_en == 1'b0, "R8 busy request ignored", ram_en, 0);
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk(ext_req == 1'b1 && ext_addr == a, "R7 held until ack", ext_addr, a);
         end
         ext_ack = 1'b1; ext_rdata = ext_val(a);
         @(negedge clk);
         ext_ack = 1'b0;
         chk(rsp_valid == 1'b1, "R7 rsp_valid after ack", rsp_valid, 1);
         chk(ext_req == 1'b0, "R7 ext_req dropped", ext_req, 0);
         if (!wr) chk(rsp_rdata == ext_val(a), "R7 ext read data", rsp_rdata, ext_val(a));
      end
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < 256; i++) begin
         ram_mem[i] = 8'(i) ^ 8'hC3;
         shadow[i]  = 8'(i) ^ 8'hC3;
      end
      repeat (3) @(negedge clk);
      chk(req_ready == 1 && rsp_valid == 0 && ext_req == 0 && ram_en == 0,
          "reset state", {req_ready, rsp_valid, ext_req, ram_en}, 4'b1000);
      rst_n = 1'b1;
      // R1: disabled after reset
      access(0, 1, 8'h00, 16'h0010, 8'h00, 1);
      access(0, 0, 8'hFF, 16'h0000, 8'h00, 2);   // R5 disabled, zero-extended
      // R2: enable via bit 4
      ctl_write(8'h10);
      access(1, 1, 8'h00, 16'h00FF, 8'hA5, 1);   // R3 boundary low
      access(0, 1, 8'h00, 16'h00FF, 8'h00, 1);
      access(0, 1, 8'h00, 16'h0100, 8'h00, 3);   // R4 boundary high
      access(1, 1, 8'h00, 16'hFFFF, 8'h3C, 1);   // R4 top
      access(0, 0, 8'hFF, 16'hFFFF, 8'h00, 1);   // R5 indirect on-chip
      // R2: other bits have no effect
      ctl_write(8'hEF);
      access(0, 1, 8'h00, 16'h0000, 8'h00, 1);
      ctl_write(8'h10);
      access(0, 1, 8'h00, 16'h0000, 8'h00, 1);
      for (int n = 0; n < 300; n++) begin
         if ($urandom_range(0, 19) == 0) ctl_write(8'($urandom));
         d = $urandom_range(0, 1) ? 16'($urandom_range(0, 511)) : 16'($urandom);
         access(1'($urandom), 1'($urandom), 8'($urandom), d, 8'($urandom),
                $urandom_range(1, 4));
      end
      summary();
      $finish;
   end
endmodule